// File: doc/BRIEF.md
# Deferred Exception Token Tracker

The tracker keeps one poison bit per architectural register for code that hoists loads above branches and checks them later. A speculative load that would have faulted does not trap. Instead it marks its destination register as poisoned. Any later operation that reads a poisoned register passes the poison on to its own result. The fault is handled only when the program runs an explicit check on a register: if the register is poisoned, control is sent to a recovery address.

The block sits beside the register file. It handles the poison bits only and never sees data values. Each cycle it accepts at most one writeback. A writeback gives the kind of operation, the destination index, up to two source indices with their use flags, and a fault flag for speculative loads. One read port returns the poison bit of any register. A check port compares the poison bit of the named register and, in the same cycle, raises a redirect carrying the recovery address supplied with the check.

Top module: `dfr_token_tracker`

## Requirements
- R1: After reset every register's token reads 0.
- R2: A writeback of kind speculative load (`wb_kind` = 2) with `wb_fault` = 1 sets the destination token, and the new value can be read in the cycle after the writeback.
- R3: A speculative load with `wb_fault` = 0 writes the token of source A to its destination when `wb_use_a` = 1, and writes 0 when `wb_use_a` = 0.
- R4: A compute writeback (`wb_kind` = 0, and also the unused code 3) writes the OR of the tokens of its used sources. A source whose use flag is 0 has no effect on the result.
- R5: A non-speculative load (`wb_kind` = 1) clears the destination token, whatever its sources and fault input are.
- R6: A check (`chk_valid` = 1) on a register whose token is set raises `redirect` in the same cycle, with `redirect_target` equal to `chk_target`.
- R7: A check on a register whose token is clear leaves `redirect` low in the same cycle. When `chk_valid` = 0, `redirect` stays low and `redirect_target` is 0.
- R8: Register 0 always reads token 0 and never causes a redirect. Writebacks to it are ignored.
- R9: The read port, the check port and the writeback sources all see the tokens as they were before any writeback in the same cycle.
- R10: A writeback changes only the token of its destination register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wb_valid | input | 1 | Writeback present this cycle |
| wb_kind | input | 2 | 0 compute, 1 load, 2 speculative load, 3 treated as compute |
| wb_dst | input | IDX_W | Destination register index |
| wb_src_a | input | IDX_W | Source A index (address register for loads) |
| wb_use_a | input | 1 | Source A is read |
| wb_src_b | input | IDX_W | Source B index |
| wb_use_b | input | 1 | Source B is read |
| wb_fault | input | 1 | Speculative load would have faulted |
| rd_idx | input | IDX_W | Token read index |
| rd_tok | output | 1 | Token of register rd_idx |
| chk_valid | input | 1 | Check command present |
| chk_idx | input | IDX_W | Register being checked |
| chk_target | input | TGT_W | Recovery address for this check |
| redirect | output | 1 | Control must go to the recovery address |
| redirect_target | output | TGT_W | Recovery address, 0 when no redirect |

## Verification
Tokens are created three ways: by faulting speculative loads, by clean speculative loads that inherit from their address register, and by compute operations that OR one or two sources. Comparing these shows whether the block confuses fault creation with inheritance, and whether it honours the use flags. Clearing loads, checks with `chk_valid` held low, and writes to register 0 show that a path which should do nothing really does nothing. One cycle drives a writeback and a read or check of the same register together, which separates pre-write visibility from a bypass. A full sweep of all tokens after the sequence catches writes that land on the wrong register.

// File: rtl/dfr_pkg.sv
package dfr_pkg;
  typedef enum logic [1:0] {
    WB_ALU  = 2'd0,
    WB_LOAD = 2'd1,
    WB_SPEC = 2'd2,
    WB_RSVD = 2'd3
  } wb_kind_e;
endpackage

// File: rtl/dfr_tok_file.sv
// Per-register poison storage; register 0 has no storage and reads zero.
module dfr_tok_file #(
  parameter int NREG  = 64,
  parameter int NRD   = 4,
  parameter int IDX_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic             wdata,
  input  logic [IDX_W-1:0] raddr [NRD],
  output logic             rdata [NRD]
);
  logic [NREG-1:0] tok_q;

  generate
    for (genvar r = 0; r < NREG; r++) begin : g_reg
      if (r == 0) begin : g_zero
        assign tok_q[r] = 1'b0;
      end else begin : g_bit
        logic bit_q, bit_d, bit_en;
        always_comb begin
          bit_en = we && (waddr == IDX_W'(r));
          bit_d  = wdata;
        end
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)      bit_q <= 1'b0;
          else if (bit_en) bit_q <= bit_d;
        end
        assign tok_q[r] = bit_q;
      end
    end
    for (genvar p = 0; p < NRD; p++) begin : g_rd
      assign rdata[p] = tok_q[raddr[p]];
    end
  endgenerate
endmodule

// File: rtl/dfr_tok_merge.sv
// Computes the token a writeback leaves in its destination.
module dfr_tok_merge
  import dfr_pkg::*;
(
  input  wb_kind_e kind,
  input  logic     fault,
  input  logic     use_a,
  input  logic     use_b,
  input  logic     tok_a,
  input  logic     tok_b,
  output logic     tok_new
);
  logic in_a, in_b;
  always_comb begin
    in_a = use_a & tok_a;
    in_b = use_b & tok_b;
    unique case (kind)
      WB_LOAD: tok_new = 1'b0;
      WB_SPEC: tok_new = fault | in_a;
      default: tok_new = in_a | in_b;
    endcase
  end
endmodule

// File: rtl/dfr_chk_unit.sv
// Resolves a check command against the token of the checked register.
module dfr_chk_unit #(
  parameter int TGT_W = 32
) (
  input  logic             chk_valid,
  input  logic             tok,
  input  logic [TGT_W-1:0] target,
  output logic             redirect,
  output logic [TGT_W-1:0] redirect_target
);
  always_comb begin
    redirect        = chk_valid & tok;
    redirect_target = redirect ? target : '0;
  end
endmodule

// File: rtl/dfr_token_tracker.sv
module dfr_token_tracker
  import dfr_pkg::*;
#(
  parameter int NREG  = 64,
  parameter int TGT_W = 32,
  parameter int IDX_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wb_valid,
  input  logic [1:0]       wb_kind,
  input  logic [IDX_W-1:0] wb_dst,
  input  logic [IDX_W-1:0] wb_src_a,
  input  logic             wb_use_a,
  input  logic [IDX_W-1:0] wb_src_b,
  input  logic             wb_use_b,
  input  logic             wb_fault,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_tok,
  input  logic             chk_valid,
  input  logic [IDX_W-1:0] chk_idx,
  input  logic [TGT_W-1:0] chk_target,
  output logic             redirect,
  output logic [TGT_W-1:0] redirect_target
);
  localparam int NRD    = 4;
  localparam int P_READ = 0;
  localparam int P_CHK  = 1;
  localparam int P_SRCA = 2;
  localparam int P_SRCB = 3;

  logic [IDX_W-1:0] raddr [NRD];
  logic             rdata [NRD];
  logic             we, wtok;
  wb_kind_e         kind;

  always_comb begin
    raddr[P_READ] = rd_idx;
    raddr[P_CHK]  = chk_idx;
    raddr[P_SRCA] = wb_src_a;
    raddr[P_SRCB] = wb_src_b;
    kind          = wb_kind_e'(wb_kind);
    we            = wb_valid && (wb_dst != '0);
  end

  dfr_tok_file #(.NREG(NREG), .NRD(NRD), .IDX_W(IDX_W)) u_file (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (we),
    .waddr (wb_dst),
    .wdata (wtok),
    .raddr (raddr),
    .rdata (rdata)
  );

  dfr_tok_merge u_merge (
    .kind    (kind),
    .fault   (wb_fault),
    .use_a   (wb_use_a),
    .use_b   (wb_use_b),
    .tok_a   (rdata[P_SRCA]),
    .tok_b   (rdata[P_SRCB]),
    .tok_new (wtok)
  );

  dfr_chk_unit #(.TGT_W(TGT_W)) u_chk (
    .chk_valid       (chk_valid),
    .tok             (rdata[P_CHK]),
    .target          (chk_target),
    .redirect        (redirect),
    .redirect_target (redirect_target)
  );

  assign rd_tok = rdata[P_READ];
endmodule

// File: rtl/dfr_token_tracker_chk.sv
module dfr_token_tracker_chk #(
  parameter int NREG  = 64,
  parameter int TGT_W = 32,
  parameter int IDX_W = $clog2(NREG)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wb_valid,
  input logic [1:0]       wb_kind,
  input logic [IDX_W-1:0] wb_dst,
  input logic             wb_fault,
  input logic [IDX_W-1:0] rd_idx,
  input logic             rd_tok,
  input logic             chk_valid,
  input logic [IDX_W-1:0] chk_idx,
  input logic [TGT_W-1:0] chk_target,
  input logic             redirect,
  input logic [TGT_W-1:0] redirect_target
);
  logic seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= 1'b1;
  end

  assert_redirect_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> (chk_valid && redirect_target == chk_target));

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_valid |-> (!redirect && redirect_target == '0));

  assert_reg0_never_redirects_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && chk_idx == '0) |-> !redirect);

  assert_fault_then_redirect_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && chk_valid && $past(wb_valid && wb_kind == 2'd2 && wb_fault && wb_dst != '0)
      && chk_idx == $past(wb_dst)) |-> redirect);

  assert_load_then_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && chk_valid && $past(wb_valid && wb_kind == 2'd1) && chk_idx == $past(wb_dst))
      |-> !redirect);

  assert_hold_without_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $past(!wb_valid) && $stable(rd_idx)) |-> $stable(rd_tok));
endmodule

bind dfr_token_tracker dfr_token_tracker_chk #(.NREG(NREG), .TGT_W(TGT_W), .IDX_W(IDX_W)) u_checker (
  .clk             (clk),
  .rst_n           (rst_n),
  .wb_valid        (wb_valid),
  .wb_kind         (wb_kind),
  .wb_dst          (wb_dst),
  .wb_fault        (wb_fault),
  .rd_idx          (rd_idx),
  .rd_tok          (rd_tok),
  .chk_valid       (chk_valid),
  .chk_idx         (chk_idx),
  .chk_target      (chk_target),
  .redirect        (redirect),
  .redirect_target (redirect_target)
);

// File: tb/tb_dfr_token_tracker.sv
`timescale 1ns/1ps
module tb_dfr_token_tracker;
  localparam int NREG  = 64;
  localparam int TGT_W = 32;
  localparam int IDX_W = $clog2(NREG);
  localparam logic [1:0] K_ALU = 2'd0, K_LOAD = 2'd1, K_SPEC = 2'd2, K_RSVD = 2'd3;

  logic clk = 1'b0;
  logic rst_n;
  logic wb_valid, wb_use_a, wb_use_b, wb_fault, chk_valid;
  logic [1:0] wb_kind;
  logic [IDX_W-1:0] wb_dst, wb_src_a, wb_src_b, rd_idx, chk_idx;
  logic [TGT_W-1:0] chk_target, redirect_target;
  logic rd_tok, redirect;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit model [NREG];

  always #10 clk = ~clk;

  dfr_token_tracker #(.NREG(NREG), .TGT_W(TGT_W)) dut (.*);

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_wb(input logic [1:0] k, input int dst, input int a, input bit ua,
                       input int b, input bit ub, input bit f);
    bit nt;
    if (k == K_LOAD)      nt = 1'b0;
    else if (k == K_SPEC) nt = f | (ua & model[a]);
    else                  nt = (ua & model[a]) | (ub & model[b]);
    @(negedge clk);
    wb_valid = 1'b1; wb_kind = k; wb_dst = IDX_W'(dst);
    wb_src_a = IDX_W'(a); wb_use_a = ua; wb_src_b = IDX_W'(b); wb_use_b = ub; wb_fault = f;
    @(posedge clk);
    #1 wb_valid = 1'b0; wb_fault = 1'b0;
    if (dst != 0) model[dst] = nt;
  endtask

  task automatic probe(input int idx, input string req);
    logic [TGT_W-1:0] tgt;
    tgt = TGT_W'(32'h1000 + idx * 16);
    @(negedge clk);
    rd_idx = IDX_W'(idx); chk_valid = 1'b1; chk_idx = IDX_W'(idx); chk_target = tgt;
    #2;
    check(rd_tok == model[idx], req, rd_tok, model[idx]);
    check(redirect == model[idx], req, redirect, model[idx]);
    check(redirect_target == (model[idx] ? tgt : '0), req, redirect_target, model[idx] ? tgt : 0);
    chk_valid = 1'b0;
  endtask

  task automatic t_reset;
    int bad = 0;
    for (int i = 0; i < NREG; i++) begin
      @(negedge clk); rd_idx = IDX_W'(i); #2;
      if (rd_tok !== 1'b0) bad++;
    end
    check(bad == 0, "R1 reset tokens", bad, 0);
  endtask

  task automatic t_spec_fault;
    do_wb(K_SPEC, 5, 0, 1'b0, 0, 1'b0, 1'b1);
    check(model[5] == 1'b1, "R2 model", model[5], 1);
    probe(5, "R2/R6 faulting speculative load");
  endtask

  task automatic t_spec_clean;
    do_wb(K_SPEC, 7, 5, 1'b1, 0, 1'b0, 1'b0);
    probe(7, "R3 inherit from address register");
    do_wb(K_SPEC, 6, 5, 1'b0, 0, 1'b0, 1'b0);
    probe(6, "R3 clean load without address source");
  endtask

  task automatic t_alu;
    do_wb(K_ALU, 8, 1, 1'b1, 5, 1'b1, 1'b0);
    probe(8, "R4 OR with one poisoned source");
    do_wb(K_ALU, 9, 1, 1'b1, 2, 1'b1, 1'b0);
    probe(9, "R4 both sources clean");
    do_wb(K_ALU, 10, 1, 1'b1, 5, 1'b0, 1'b0);
    probe(10, "R4 unused poisoned source ignored");
    do_wb(K_RSVD, 12, 5, 1'b1, 0, 1'b0, 1'b1);
    probe(12, "R4 code 3 behaves as compute");
  endtask

  task automatic t_load_clear;
    do_wb(K_LOAD, 8, 5, 1'b1, 7, 1'b1, 1'b1);
    probe(8, "R5 load clears token");
    probe(9, "R7 clear token no redirect");
    @(negedge clk);
    chk_valid = 1'b0; chk_idx = IDX_W'(7); chk_target = 32'hDEAD;
    #2;
    check(redirect == 1'b0, "R7 inactive check", redirect, 0);
    check(redirect_target == '0, "R7 inactive target", redirect_target, 0);
  endtask

  task automatic t_reg0;
    do_wb(K_SPEC, 0, 0, 1'b0, 0, 1'b0, 1'b1);
    probe(0, "R8 register 0 ignores faulting write");
    do_wb(K_ALU, 0, 5, 1'b1, 7, 1'b1, 1'b0);
    probe(0, "R8 register 0 ignores poisoned compute");
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    wb_valid = 1'b1; wb_kind = K_SPEC; wb_dst = IDX_W'(11); wb_use_a = 1'b0; wb_use_b = 1'b0;
    wb_fault = 1'b1; rd_idx = IDX_W'(11); chk_valid = 1'b1; chk_idx = IDX_W'(11);
    chk_target = 32'hBEEF;
    #2;
    check(rd_tok == 1'b0, "R9 read sees old token", rd_tok, 0);
    check(redirect == 1'b0, "R9 check sees old token", redirect, 0);
    @(posedge clk);
    #1 wb_valid = 1'b0; wb_fault = 1'b0; chk_valid = 1'b0;
    model[11] = 1'b1;
    probe(11, "R9 token visible next cycle");
    // Destination equal to source, load clears while reading its own old token.
    do_wb(K_ALU, 13, 13, 1'b1, 11, 1'b1, 1'b0);
    do_wb(K_LOAD, 11, 11, 1'b1, 0, 1'b0, 1'b0);
    probe(11, "R9 self-sourced load");
    probe(13, "R9 source sampled before write");
  endtask

  task automatic t_isolation;
    int bad = 0;
    do_wb(K_SPEC, 20, 0, 1'b0, 0, 1'b0, 1'b1);
    for (int i = 0; i < NREG; i++) begin
      @(negedge clk); rd_idx = IDX_W'(i); #2;
      if (rd_tok !== model[i]) begin
        bad++;
        $display("FAIL R10 reg %0d actual=%0b expected=%0b", i, rd_tok, model[i]);
      end
    end
    check(bad == 0, "R10 full sweep", bad, 0);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NREG; i++) model[i] = 1'b0;
    rst_n = 1'b0; wb_valid = 1'b0; wb_kind = K_ALU; wb_dst = '0; wb_src_a = '0;
    wb_use_a = 1'b0; wb_src_b = '0; wb_use_b = 1'b0; wb_fault = 1'b0;
    rd_idx = '0; chk_valid = 1'b0; chk_idx = '0; chk_target = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset;
    t_spec_fault;
    t_spec_clean;
    t_alu;
    t_load_clear;
    t_reg0;
    t_same_cycle;
    t_isolation;
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule